// File: doc/BRIEF.md
# Strap-Latched Clock Divider Network

This block turns one fast digital reference clock into a set of per-domain clock-enable pulses for a clock generator: a CPU domain, a 66 MHz domain, a 33 MHz PCI domain, a 48 MHz domain and a reference domain. Each pulse is one fast-clock cycle wide and recurs at that domain's divide ratio. The ratios are chosen by two board straps: a three-level mode strap, delivered already encoded on two bits, and a one-bit frequency strap.

The straps are read once, in the first cycle in which the active-low power-good strobe is seen low. After that the strobe and the straps are ignored until reset. The latched values are exported for register readback, along with a lock flag. In the high mode, the 66 MHz domain follows an external 66 MHz tick input, and PCI runs at half of that input. In the low mode, both come from internal counters. The mid level selects a test mode in which the fast clock itself is divided by fixed small ratios. One strap combination is reserved and silences every output.

The 66 MHz and PCI pulses come from a single shared counter chain, so every PCI pulse coincides with a 66 MHz pulse.

Top module: `strap_clk_divider`

## Requirements
- R1: While `rst_n` is low, every tick output, `locked`, `reserved`, `ext66_mode`, `mode_rb` and `freq_rb` are 0.
- R2: After reset and before `pg_n` has been sampled low, no tick is produced and `locked` stays 0. On the first rising clock edge with `pg_n` low, the straps are captured and `locked` becomes 1.
- R3: Once `locked` is 1, changes on `pg_n`, `mode_strap` and `freq_strap` have no effect on the readback values or on any tick output until the next reset.
- R4: With the mode strap low (`mode_strap` = 2'b00) and `freq_strap` = 0, `cpu_tick` pulses every DIV_CPU_LO cycles. The first pulse falls in the first cycle with `locked` high.
- R5: With `freq_strap` = 1 in the low or high mode, `cpu_tick` pulses every DIV_CPU_HI cycles, again starting in the first locked cycle.
- R6: In the low mode, `m66_tick` pulses every DIV_66 cycles and `pci_tick` every 2*DIV_66 cycles, both starting in the first locked cycle. Every `pci_tick` pulse coincides with an `m66_tick` pulse.
- R7: With the mode strap high (`mode_strap` = 2'b10), `ext66_mode` is 1 and `m66_tick` equals `ext66_in` in every cycle. `pci_tick` fires on the 1st, 3rd, 5th and later odd-numbered `ext66_in` pulses seen after lock.
- R8: In the low and high modes, `usb_tick` pulses every DIV_USB cycles and `ref_tick` every DIV_REF cycles, starting in the first locked cycle.
- R9: With the mode strap mid (`mode_strap` = 2'b01) and `freq_strap` = 0, the block is in test mode. `cpu_tick` and `usb_tick` pulse every 2 cycles, `m66_tick` every 4, `pci_tick` every 8, and `ref_tick` is high in every locked cycle.
- R10: In a reserved combination, `reserved` is 1 and every tick output stays 0. The reserved combinations are mid with `freq_strap` = 1, and the unused code 2'b11 with either frequency.
- R11: After lock, `mode_rb` and `freq_rb` equal the strap values that were present on the locking edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock (also the test clock) |
| rst_n | input | 1 | Asynchronous active-low reset |
| pg_n | input | 1 | Active-low power-good strobe, synchronous to clk |
| mode_strap | input | 2 | Encoded mode strap: 00 low, 01 mid, 10 high, 11 unused |
| freq_strap | input | 1 | Frequency strap: 0 selects the slower CPU rate, 1 the faster |
| ext66_in | input | 1 | External 66 MHz tick, one cycle per input period |
| cpu_tick | output | 1 | CPU domain enable pulse |
| m66_tick | output | 1 | 66 MHz domain enable pulse |
| pci_tick | output | 1 | PCI domain enable pulse |
| usb_tick | output | 1 | 48 MHz domain enable pulse |
| ref_tick | output | 1 | Reference domain enable pulse |
| ext66_mode | output | 1 | High when the 66 MHz domain follows the external input |
| reserved | output | 1 | High when the latched straps form a reserved combination |
| locked | output | 1 | Straps have been captured |
| mode_rb | output | 2 | Latched mode strap for readback |
| freq_rb | output | 1 | Latched frequency strap for readback |

## Verification
The bench targets the capture instant and the first locked cycle. A latch that stayed open would follow strap or strobe changes made after lock. A divider that started off phase would put its first pulse somewhere other than the first locked cycle.

In the high mode, external ticks are driven at irregular spacing. A design that ran PCI from an internal counter would drift against the input, and one that counted pulses from the wrong parity would fire on the even pulses.

Both reserved codes are checked for total silence, because a decoder that missed code 11 would produce low-mode clocks. Test mode is checked for a reference enable held high in every cycle. This catches a divider whose limit of one is mishandled.

// File: rtl/strap_clk_divider_pkg.sv
package strap_clk_divider_pkg;

    typedef enum logic [1:0] {
        STRAP_LOW  = 2'b00,
        STRAP_MID  = 2'b01,
        STRAP_HIGH = 2'b10,
        STRAP_BAD  = 2'b11
    } strap_mode_e;

    typedef struct packed {
        logic        lock;
        strap_mode_e mode;
        logic        freq;
    } strap_state_t;

    // fixed test-mode ratios applied to the incoming test clock
    localparam int TST_CPU = 2;
    localparam int TST_66  = 4;
    localparam int TST_USB = 2;
    localparam int TST_REF = 1;

endpackage

// File: rtl/strap_latch.sv
module strap_latch
    import strap_clk_divider_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pg_n,
    input  logic [1:0]  mode_in,
    input  logic        freq_in,
    output logic        locked,
    output strap_mode_e mode,
    output logic        freq
);

    strap_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.lock && !pg_n) begin
            st_d.lock = 1'b1;
            st_d.mode = strap_mode_e'(mode_in);
            st_d.freq = freq_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{lock: 1'b0, mode: STRAP_LOW, freq: 1'b0};
        else        st_q <= st_d;
    end

    assign locked = st_q.lock;
    assign mode   = st_q.mode;
    assign freq   = st_q.freq;

endmodule

// File: rtl/tick_div.sv
module tick_div #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         adv,
    input  logic [W-1:0] lim,
    output logic         tick
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run)            cnt_d = '0;
        else if (adv)        cnt_d = (cnt_q >= lim - W'(1)) ? '0 : cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = run && adv && (cnt_q == '0);

endmodule

// File: rtl/div_chain.sv
module div_chain #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         adv,
    input  logic [W-1:0] half,
    output logic         t66,
    output logic         tpci
);

    localparam int CW = W + 1;

    logic [CW-1:0] c_d, c_q;
    logic [CW-1:0] half_x, last;

    always_comb begin
        half_x = CW'(half);
        last   = (half_x << 1) - CW'(1);
        c_d    = c_q;
        if (!run)     c_d = '0;
        else if (adv) c_d = (c_q >= last) ? '0 : c_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign t66  = run && adv && ((c_q == '0) || (c_q == half_x));
    assign tpci = run && adv && (c_q == '0);

endmodule

// File: rtl/strap_clk_divider.sv
module strap_clk_divider
    import strap_clk_divider_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int DIV_CPU_LO = 4,
    parameter int DIV_CPU_HI = 3,
    parameter int DIV_66     = 6,
    parameter int DIV_USB    = 8,
    parameter int DIV_REF    = 28
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pg_n,
    input  logic [1:0] mode_strap,
    input  logic       freq_strap,
    input  logic       ext66_in,
    output logic       cpu_tick,
    output logic       m66_tick,
    output logic       pci_tick,
    output logic       usb_tick,
    output logic       ref_tick,
    output logic       ext66_mode,
    output logic       reserved,
    output logic       locked,
    output logic [1:0] mode_rb,
    output logic       freq_rb
);

    localparam int NDIV = 3;   // cpu, usb, ref

    strap_mode_e      mode_l;
    logic             freq_l;
    logic             run, is_mid, is_high, chain_adv;
    logic [CNT_W-1:0] lim [NDIV];
    logic [CNT_W-1:0] half;
    logic [NDIV-1:0]  ticks;

    strap_latch u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .pg_n    (pg_n),
        .mode_in (mode_strap),
        .freq_in (freq_strap),
        .locked  (locked),
        .mode    (mode_l),
        .freq    (freq_l)
    );

    always_comb begin
        is_mid    = (mode_l == STRAP_MID);
        is_high   = (mode_l == STRAP_HIGH);
        reserved  = locked && ((mode_l == STRAP_BAD) || (is_mid && freq_l));
        run       = locked && !reserved;
        chain_adv = is_high ? ext66_in : 1'b1;
        if (is_mid) begin
            lim[0] = CNT_W'(TST_CPU);
            lim[1] = CNT_W'(TST_USB);
            lim[2] = CNT_W'(TST_REF);
            half   = CNT_W'(TST_66);
        end else begin
            lim[0] = freq_l ? CNT_W'(DIV_CPU_HI) : CNT_W'(DIV_CPU_LO);
            lim[1] = CNT_W'(DIV_USB);
            lim[2] = CNT_W'(DIV_REF);
            half   = is_high ? CNT_W'(1) : CNT_W'(DIV_66);
        end
    end

    for (genvar g = 0; g < NDIV; g++) begin : g_div
        tick_div #(.W(CNT_W)) u_div (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (run),
            .adv   (1'b1),
            .lim   (lim[g]),
            .tick  (ticks[g])
        );
    end

    div_chain #(.W(CNT_W)) u_chain (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .adv   (chain_adv),
        .half  (half),
        .t66   (m66_tick),
        .tpci  (pci_tick)
    );

    assign cpu_tick   = ticks[0];
    assign usb_tick   = ticks[1];
    assign ref_tick   = ticks[2];
    assign ext66_mode = locked && is_high;
    assign mode_rb    = mode_l;
    assign freq_rb    = freq_l;

endmodule

// File: rtl/strap_clk_divider_chk.sv
module strap_clk_divider_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ext66_in,
    input logic       cpu_tick,
    input logic       m66_tick,
    input logic       pci_tick,
    input logic       usb_tick,
    input logic       ref_tick,
    input logic       ext66_mode,
    input logic       reserved,
    input logic       locked,
    input logic [1:0] mode_rb,
    input logic       freq_rb
);

    logic any_tick;
    assign any_tick = cpu_tick | m66_tick | pci_tick | usb_tick | ref_tick;

    // R2
    a_r2_quiet_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> !any_tick);

    // R3
    a_r3_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    // R3, R11
    a_r3_readback_held: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> ($stable(mode_rb) && $stable(freq_rb)));

    // R6
    a_r6_pci_on_66: assert property (@(posedge clk) disable iff (!rst_n)
        pci_tick |-> m66_tick);

    // R7
    a_r7_follow_ext: assert property (@(posedge clk) disable iff (!rst_n)
        ext66_mode |-> (m66_tick == ext66_in));

    // R9
    a_r9_ref_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && mode_rb == 2'b01 && !freq_rb) |-> ref_tick);

    // R10
    a_r10_reserved_silent: assert property (@(posedge clk) disable iff (!rst_n)
        reserved |-> !any_tick);

endmodule

bind strap_clk_divider strap_clk_divider_chk u_chk (.*);

// File: tb/strap_clk_divider_test.sv
module strap_clk_divider_test;

    localparam int CLK_PERIOD = 10;
    localparam int D_CPU_LO = 4, D_CPU_HI = 3, D_66 = 6, D_USB = 8, D_REF = 28;

    logic clk = 0, rst_n = 0, pg_n = 1, freq_strap = 0, ext66_in = 0;
    logic [1:0] mode_strap = 2'b00;
    logic cpu_tick, m66_tick, pci_tick, usb_tick, ref_tick;
    logic ext66_mode, reserved, locked, freq_rb;
    logic [1:0] mode_rb;

    int checks = 0, errors = 0;
    bit finished = 0;

    strap_clk_divider uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int due(int n, int d);
        return (d != 0 && n % d == 0) ? 1 : 0;
    endfunction

    // reset, present straps, drop pg_n; returns in the first locked cycle (n = 0)
    task automatic restart(input logic [1:0] m, input logic f);
        rst_n = 0; pg_n = 1; mode_strap = m; freq_strap = f; ext66_in = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        pg_n = 0;
        @(negedge clk);
    endtask

    // d66 < 0 selects external-follow expectations; ext_gap > 0 drives irregular ext ticks
    task automatic watch(string req, int cycles, int dcpu, int d66, int dusb, int dref,
                         int ext_gap, bit perturb);
        int k = 0;
        for (int n = 0; n < cycles; n++) begin
            int e66, epci;
            if (n > 0) @(negedge clk);
            ext66_in = (ext_gap > 0) && ((n % ext_gap == 0) || (n % 7 == 5));
            if (perturb && n == 10) begin
                mode_strap = ~mode_strap; freq_strap = ~freq_strap; pg_n = 1;
            end
            if (perturb && n == 20) pg_n = 0;
            #1;
            if (d66 < 0) begin
                e66  = ext66_in;
                epci = (ext66_in && k % 2 == 0) ? 1 : 0;
                if (ext66_in) k++;
            end else begin
                e66  = due(n, d66);
                epci = due(n, 2 * d66);
            end
            chk(req, $sformatf("cpu_tick n=%0d", n), cpu_tick, due(n, dcpu));
            chk(req, $sformatf("m66_tick n=%0d", n), m66_tick, e66);
            chk(req, $sformatf("pci_tick n=%0d", n), pci_tick, epci);
            chk(req, $sformatf("usb_tick n=%0d", n), usb_tick, due(n, dusb));
            chk(req, $sformatf("ref_tick n=%0d", n), ref_tick, due(n, dref));
        end
        ext66_in = 0;
    endtask

    task automatic test_reset();
        rst_n = 0; pg_n = 0; mode_strap = 2'b10; freq_strap = 1;
        repeat (2) @(negedge clk); #1;
        chk("R1", "ticks in reset", {cpu_tick, m66_tick, pci_tick, usb_tick, ref_tick}, 0);
        chk("R1", "locked in reset", locked, 0);
        chk("R1", "flags in reset", {reserved, ext66_mode}, 0);
        chk("R1", "readback in reset", {mode_rb, freq_rb}, 0);
        pg_n = 1; mode_strap = 2'b00; freq_strap = 0;
        @(negedge clk); rst_n = 1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); #1;
            chk("R2", "ticks before power-good",
                {cpu_tick, m66_tick, pci_tick, usb_tick, ref_tick}, 0);
            chk("R2", "locked before power-good", locked, 0);
        end
        pg_n = 0;
        @(negedge clk); #1;
        chk("R2", "locked after power-good low", locked, 1);
    endtask

    task automatic test_low_slow();
        restart(2'b00, 1'b0);
        chk("R11", "mode_rb low", mode_rb, 0);
        chk("R11", "freq_rb 0", freq_rb, 0);
        chk("R7", "ext66_mode in low mode", ext66_mode, 0);
        watch("R4 R6 R8", 60, D_CPU_LO, D_66, D_USB, D_REF, 0, 0);
    endtask

    task automatic test_low_fast_ignore();
        restart(2'b00, 1'b1);
        watch("R5 R3", 60, D_CPU_HI, D_66, D_USB, D_REF, 0, 1);
        #1;
        chk("R3", "mode_rb after strap change", mode_rb, 0);
        chk("R3", "freq_rb after strap change", freq_rb, 1);
        chk("R3", "locked after pg_n toggle", locked, 1);
    endtask

    task automatic test_high();
        restart(2'b10, 1'b1);
        chk("R7", "ext66_mode high mode", ext66_mode, 1);
        chk("R11", "mode_rb high", mode_rb, 2);
        watch("R7 R5 R8", 60, D_CPU_HI, -1, D_USB, D_REF, 3, 0);
    endtask

    task automatic test_mid();
        restart(2'b01, 1'b0);
        chk("R9", "reserved in test mode", reserved, 0);
        watch("R9", 40, 2, 4, 2, 1, 0, 0);
    endtask

    task automatic test_reserved();
        restart(2'b01, 1'b1);
        chk("R10", "reserved flag mid/1", reserved, 1);
        watch("R10", 30, 0, 0, 0, 0, 0, 0);
        restart(2'b11, 1'b0);
        chk("R10", "reserved flag code 11", reserved, 1);
        watch("R10", 30, 0, 0, 0, 0, 3, 0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        test_reset();
        test_low_slow();
        test_low_fast_ignore();
        test_high();
        test_mid();
        test_reserved();
        summary();
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

endmodule